// File: doc/BRIEF.md
# Counted Gate-Time Stop Controller

This block closes a measurement window once a programmed number of gated clock pulses has gone out. An init strobe loads a 16-bit preset into a down counter and clears the stop flag. After that, every cycle in which the window is armed, the raw clock qualifier is high and the stop flag is clear produces one gated clock enable. The gated clock enable feeds the downstream signature and event logic, and each such pulse also decrements the counter.

The pulse that takes the counter to zero sets the stop flag on that same clock edge. From the next cycle onward, the gated clock enable is held low. The window therefore delivers exactly as many pulses as the preset asks for, never one more. A done output pulses for one cycle in the first cycle that the stop flag reads set. A preset of zero stops the window immediately, and no pulse is delivered. The gated clock enable is a clock-enable strobe in the `clk` domain. It is not a derived clock.

Top module: `gate_window_stop`

## Requirements
- R1: Out of reset, `stopped` is 1, `done` is 0, and `gate_en` is 0 whatever `arm` and `clk_qual` are.
- R2: When `init` is 1 with a nonzero `preset`, that preset becomes the remaining count and `stopped` reads 0 in the next cycle. `gate_en` is 0 in the cycle where `init` is 1.
- R3: When `init` is 0, `gate_en` is 1 exactly when `arm`, `clk_qual` and the inverse of `stopped` are all 1 in that same cycle.
- R4: After an init with a nonzero preset N, the window delivers exactly N cycles with `gate_en` = 1 before it stops.
- R5: The edge that ends the Nth delivered pulse sets `stopped`. No `gate_en` pulse occurs while `stopped` is 1.
- R6: `done` is 1 for exactly the one cycle in which `stopped` first reads 1 after becoming set. At all other times `done` is 0.
- R7: An init with `preset` = 0 makes `stopped` read 1 and `done` read 1 in the next cycle, and no pulse is delivered.
- R8: An init while a window is still running discards the remaining count and starts a new window of the new preset. It does not raise `done` unless the new preset is zero.
- R9: Cycles with `arm` = 0 or `clk_qual` = 0 deliver no pulse and leave the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_qual | input | 1 | Raw gated-clock qualifier, one candidate pulse per cycle it is high |
| arm | input | 1 | Window armed level |
| init | input | 1 | Init strobe: load the preset and clear the stop flag |
| preset | input | CNT_W (16) | Number of pulses in the window |
| gate_en | output | 1 | Gated clock enable toward the downstream sections |
| stopped | output | 1 | Stop flag |
| done | output | 1 | One-cycle pulse when the stop flag becomes set |

## Verification
A wrong remaining count shows at the ports within one window: the number of `gate_en` pulses between the init and `done` comes out wrong. A lost or early stop appears on the very cycle after the bad edge, as an extra pulse or a missing pulse on `gate_en`. A stop flag that is wrongly set or cleared shows on `stopped` in the same cycle, and a `done` pulse out of place shows immediately as well. The bench's behavioural model predicts all three outputs every cycle, so the first divergence is reported in the cycle it occurs.

// File: rtl/gws_pkg.sv
package gws_pkg;
  // Events that steer the stop flag in one cycle
  typedef struct packed {
    logic load;         // init strobe
    logic pulse;        // gated pulse delivered this cycle
    logic zero_preset;  // preset presented with init is zero
  } win_evt_t;

  // stop becomes set: a zero-preset load, or the final pulse of a window
  function automatic logic stop_set(win_evt_t e, logic reach_zero);
    return (e.load && e.zero_preset) || (!e.load && reach_zero);
  endfunction

  // stop is cleared by a load with a nonzero preset
  function automatic logic stop_clear(win_evt_t e);
    return e.load && !e.zero_preset;
  endfunction
endpackage

// File: rtl/gws_down_counter.sv
module gws_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             reach_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] dec_one(logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  function automatic logic is_last(logic [CNT_W-1:0] v);
    return v == ONE;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  assign count      = cnt_q;
  assign reach_zero = dec && !load && is_last(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (dec && cnt_q != '0)     cnt_q <= dec_one(cnt_q);
  end

  // R9: no load and no delivered pulse leaves the count alone
  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec) |=> $stable(count));
endmodule

// File: rtl/gws_stop_latch.sv
module gws_stop_latch
  import gws_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  win_evt_t evt,
  input  logic     reach_zero,
  output logic     stop_q,
  output logic     set_pulse
);
  logic set_evt;
  logic clr_evt;

  assign set_evt = stop_set(evt, reach_zero);
  assign clr_evt = stop_clear(evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q    <= 1'b1;
      set_pulse <= 1'b0;
    end else begin
      set_pulse <= set_evt;
      if (set_evt)      stop_q <= 1'b1;
      else if (clr_evt) stop_q <= 1'b0;
    end
  end

  // R6: done only ever accompanies a set stop flag
  p_done_with_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> stop_q);
endmodule

// File: rtl/gate_window_stop.sv
module gate_window_stop
  import gws_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_qual,
  input  logic             arm,
  input  logic             init,
  input  logic [CNT_W-1:0] preset,
  output logic             gate_en,
  output logic             stopped,
  output logic             done
);
  // named internal events, visible to the assertions
  win_evt_t         evt;
  logic             reach_zero;
  logic             stop_q;
  logic [CNT_W-1:0] remain;

  assign gate_en         = arm && clk_qual && !init && !stop_q;
  assign evt.load        = init;
  assign evt.pulse       = gate_en;
  assign evt.zero_preset = (preset == '0);

  gws_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (init),
    .load_val  (preset),
    .dec       (evt.pulse),
    .count     (remain),
    .reach_zero(reach_zero)
  );

  gws_stop_latch u_stop (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .reach_zero(reach_zero),
    .stop_q    (stop_q),
    .set_pulse (done)
  );

  assign stopped = stop_q;

  // R5: a running window always has pulses left
  p_running_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped |-> (remain != '0));
  // R5: the final pulse is followed by no further pulse
  p_no_extra_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reach_zero |=> (stopped && !gate_en));
  // R2: nonzero preset load opens the window with that count
  p_load_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (init && preset != '0) |=> (!stopped && remain == $past(preset) && !done));
  // R7: zero preset load stops at once and flags done
  p_zero_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (init && preset == '0) |=> (stopped && done));
endmodule

// File: tb/test_gate_window_stop.sv
module test_gate_window_stop;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_qual = 1'b0;
  logic        arm = 1'b0;
  logic        init = 1'b0;
  logic [15:0] preset = '0;
  logic        gate_en, stopped, done;

  int tests = 0;
  int fails = 0;

  // behavioural model state
  int m_count = 0;
  bit m_stop  = 1'b1;
  bit m_done  = 1'b0;
  int w_pulses = 0;
  int w_preset = 0;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  gate_window_stop i_gate_window_stop (
    .clk(clk), .rst_n(rst_n), .clk_qual(clk_qual), .arm(arm), .init(init),
    .preset(preset), .gate_en(gate_en), .stopped(stopped), .done(done)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit a, input bit q, input bit i, input int p);
    bit exp_gate;
    @(negedge clk);
    arm = a; clk_qual = q; init = i; preset = 16'(p);
    #1;
    exp_gate = a && q && !i && !m_stop;
    chk(tag, "gate_en", gate_en, exp_gate);
    chk(tag, "stopped", stopped, m_stop);
    chk(tag, "done", done, m_done);
    @(posedge clk);
    if (i) begin
      m_count  = p;
      m_stop   = (p == 0);
      m_done   = (p == 0);
      w_pulses = 0;
      w_preset = p;
    end else if (exp_gate) begin
      w_pulses++;
      m_count--;
      m_done = (m_count == 0);
      if (m_count == 0) begin
        m_stop = 1'b1;
        tests++;
        if (w_pulses != w_preset) begin // R4 pulse tally per window
          fails++;
          $display("FAIL R4 window pulses act=%0d exp=%0d", w_pulses, w_preset);
        end
      end
    end else begin
      m_done = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state, even with arm and qualifier high
    arm = 1'b1; clk_qual = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "gate_en", gate_en, 1'b0);
    chk("R1", "stopped", stopped, 1'b1);
    chk("R1", "done", done, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step("R1", 1, 1, 0, 0);

    // R2/R4: load 3, qualifier always high
    step("R2", 1, 1, 1, 3);
    repeat (6) step("R4", 1, 1, 0, 0);

    // R7: zero preset
    step("R7", 1, 1, 1, 0);
    repeat (3) step("R7", 1, 1, 0, 0);

    // R9: disarmed or unqualified cycles are not counted
    step("R9", 1, 1, 1, 4);
    repeat (3) step("R9", 0, 1, 0, 0);
    repeat (2) step("R9", 1, 0, 0, 0);
    repeat (6) step("R9", 1, 1, 0, 0);

    // R8: re-init mid window
    step("R8", 1, 1, 1, 5);
    repeat (2) step("R8", 1, 1, 0, 0);
    step("R8", 1, 1, 1, 2);
    repeat (4) step("R8", 1, 1, 0, 0);
    step("R8", 1, 1, 1, 0);
    repeat (2) step("R8", 1, 1, 0, 0);

    // R6/R5: single pulse window, then repeated windows
    step("R6", 1, 1, 1, 1);
    repeat (3) step("R6", 1, 1, 0, 0);
    step("R5", 1, 1, 1, 300);
    repeat (305) step("R5", 1, 1, 0, 0);

    // R3: mixed patterns
    for (int k = 0; k < 2000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R3", lf[0] | lf[5], lf[1] | lf[9], (lf[4:0] == 5'd7), int'(lf[8:6]));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule